// File: doc/BRIEF.md
# Watch-State Clock and Pad Controller

This block puts a processor core into a low-power watch state. The oscillator stays up the whole time. While the core is asleep, the block turns off the CPU clock enable and the internal system clock enable. Timekeeping logic runs from the oscillator domain, which this block never gates. Software requests the watch state by writing an entry code to the power-mode field. The block sleeps until one of three things happens: a non-maskable request, a maskable request whose mask bit is clear, or reset.

When an interrupt wakes the core, the CPU stays stopped for a fixed number of oscillator cycles so the oscillator can settle. The block then hands control back. At that moment it may raise a one-cycle acknowledge-enable toward the interrupt controller. It raises it only when the waking request outranks the handler that was running when the core went to sleep. A lower-ranked request still wakes the core, but it is not acknowledged and remains pending in the interrupt controller.

While the core sleeps, the block holds the external bus in its idle state. The data and address drivers are released, the read, write and chip-select strobes sit high, and the clock output sits low. The external wait input is masked, and the general-purpose outputs keep their last value.

Top module: `lpw_ctrl`

## Requirements
- R1: In the run state, a cycle with `pm_wr` high and `pm_code` equal to 2'b10 moves the block to the watch state at the next clock edge. There `in_watch` is 1, and `cpu_clk_en` and `sys_clk_en` are 0. A write with any other code leaves the block running.
- R2: `cpu_clk_en` and `sys_clk_en` stay 0 for the whole sleep period, which covers the watch state and the stabilization count.
- R3: In the watch state, a high `nmi_req`, or any bit of `irq_req` whose `irq_mask` bit (1 = masked) is 0, ends the watch state at the next edge. Requests whose mask bit is 1 leave the block in the watch state.
- R4: After a wake, `cpu_clk_en` returns to 1 exactly `STAB_CYCLES` clock edges after the edge that sampled the wake request.
- R5: `ack_en` is a single-cycle pulse, coinciding with the first cycle of `cpu_clk_en` = 1 after the count. It is raised when the wake was due to `nmi_req`, when `isr_active` was 0, or when the highest `PRIO_W`-bit priority among unmasked waking requests is numerically greater than `isr_prio`. Lane i's priority is `irq_prio[i*PRIO_W +: PRIO_W]`, and a larger value means a higher priority.
- R6: If `isr_active` is 1, there is no `nmi_req`, and the highest waking priority is less than or equal to `isr_prio`, the core restarts after the same count with no `ack_en` pulse.
- R7: A low `rst_n` at a clock edge returns the block to the run state at once, from any state. It produces no `ack_en` pulse, and the stabilization count restarts from zero on the next entry.
- R8: During sleep, `pad_data_oe` and `pad_addr_oe` are 0, `pad_rd_n`, `pad_uwr_n`, `pad_lwr_n` and all bits of `pad_cs_n` are 1, and `pad_clkout` is 0.
- R9: During sleep, `core_wait` is 0 whatever `ext_wait` does, and `gpio_o` keeps the value it had in the last run cycle.
- R10: In the run state, every pad output, `core_wait` and `gpio_o` equal the corresponding core-side input.
- R11: Power-mode writes made while asleep have no effect on the sleep state or on the stabilization count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_wr | input | 1 | Power-mode field write strobe |
| pm_code | input | 2 | Power-mode code; 2'b10 requests watch |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | IRQ_N | Maskable request lines |
| irq_mask | input | IRQ_N | Mask bits, 1 = masked |
| irq_prio | input | IRQ_N*PRIO_W | Packed per-lane priority |
| isr_active | input | 1 | A handler is in service |
| isr_prio | input | PRIO_W | Priority of the handler in service |
| core_data_o | input | DATA_W | Core data bus output |
| core_data_oe | input | 1 | Core data drive enable |
| core_addr | input | ADDR_W | Core address |
| core_addr_oe | input | 1 | Core address drive enable |
| core_rd_n | input | 1 | Core read strobe |
| core_uwr_n | input | 1 | Core upper-byte write strobe |
| core_lwr_n | input | 1 | Core lower-byte write strobe |
| core_cs_n | input | CS_N | Core chip selects |
| core_clkout | input | 1 | Core clock output |
| core_gpio | input | IO_W | Core general-purpose outputs |
| ext_wait | input | 1 | External wait input |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | Internal system clock enable |
| in_watch | output | 1 | Watch state, awaiting wake |
| ack_en | output | 1 | One-cycle acknowledge enable |
| pad_data_o | output | DATA_W | Data pad value |
| pad_data_oe | output | 1 | Data pad drive enable |
| pad_addr_o | output | ADDR_W | Address pad value |
| pad_addr_oe | output | 1 | Address pad drive enable |
| pad_rd_n | output | 1 | Read strobe pad |
| pad_uwr_n | output | 1 | Upper write strobe pad |
| pad_lwr_n | output | 1 | Lower write strobe pad |
| pad_cs_n | output | CS_N | Chip-select pads |
| pad_clkout | output | 1 | Clock output pad |
| core_wait | output | 1 | Wait seen by the core |
| gpio_o | output | IO_W | General-purpose output pads |

## Verification
The assertions assume that `rst_n` is low at the first edge and that `pm_code` and the request inputs are never X once reset is released. The bench keeps to this by driving every input to a known value from time zero and changing them only at falling edges. The acknowledge checks also assume that a waking request is held for exactly one sampling edge. The stimulus raises each wake pattern at one falling edge and clears it at the next, so the priority decision is taken from a single, stable set of inputs.

// File: rtl/lpw_pkg.sv
// Shared types for the watch-state controller.
// Assumes: none; pure declarations.
package lpw_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WATCH = 2'd1,
        ST_STAB  = 2'd2
    } lpw_state_e;

    localparam logic [1:0] PM_CODE_WATCH = 2'b10;
endpackage

// File: rtl/lpw_wake_eval.sv
// Wake evaluation: decides whether the current requests end the watch state
// and whether the waking request outranks the handler in service.
// Assumes: larger priority value = higher priority; NMI outranks everything.
module lpw_wake_eval #(
    parameter int IRQ_N  = 8,
    parameter int PRIO_W = 3
) (
    input  logic                    nmi_req,
    input  logic [IRQ_N-1:0]        irq_req,
    input  logic [IRQ_N-1:0]        irq_mask,
    input  logic [IRQ_N*PRIO_W-1:0] irq_prio,
    input  logic                    isr_active,
    input  logic [PRIO_W-1:0]       isr_prio,
    output logic                    wake,
    output logic                    grant
);
    logic [IRQ_N-1:0]  live;
    logic [PRIO_W-1:0] top_prio;

    assign live = irq_req & ~irq_mask;

    // Find the highest priority among unmasked pending lanes.
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < IRQ_N; i++) begin
            if (live[i] && (irq_prio[i*PRIO_W +: PRIO_W] > top_prio))
                top_prio = irq_prio[i*PRIO_W +: PRIO_W];
        end
    end

    // Wake on any live source; acknowledge only if it outranks the handler.
    always_comb begin
        wake  = nmi_req || (|live);
        grant = nmi_req || ((|live) && (!isr_active || (top_prio > isr_prio)));
    end
endmodule

// File: rtl/lpw_stab_timer.sv
// Stabilization counter: counts oscillator cycles while enabled and flags
// the last cycle of the interval.
// Assumes: run stays high until done; cleared whenever run is low.
module lpw_stab_timer #(
    parameter int STAB_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count up while running, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/lpw_pad_idle.sv
// Pad idling: passes core bus signals through while running, forces the
// idle levels while asleep, masks wait and holds general outputs.
// Assumes: sleep is a registered state-derived signal.
module lpw_pad_idle #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 24,
    parameter int CS_N   = 3,
    parameter int IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] core_data_o,
    input  logic              core_data_oe,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_addr_oe,
    input  logic              core_rd_n,
    input  logic              core_uwr_n,
    input  logic              core_lwr_n,
    input  logic [CS_N-1:0]   core_cs_n,
    input  logic              core_clkout,
    input  logic [IO_W-1:0]   core_gpio,
    input  logic              ext_wait,
    output logic [DATA_W-1:0] pad_data_o,
    output logic              pad_data_oe,
    output logic [ADDR_W-1:0] pad_addr_o,
    output logic              pad_addr_oe,
    output logic              pad_rd_n,
    output logic              pad_uwr_n,
    output logic              pad_lwr_n,
    output logic [CS_N-1:0]   pad_cs_n,
    output logic              pad_clkout,
    output logic              core_wait,
    output logic [IO_W-1:0]   gpio_o
);
    logic [IO_W-1:0] gpio_hold;

    // Remember the general outputs of the last running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gpio_hold <= '0;
        else if (!sleep)
            gpio_hold <= core_gpio;
    end

    // Select idle levels or core values for every pad.
    always_comb begin
        pad_data_o  = core_data_o;
        pad_addr_o  = core_addr;
        pad_data_oe = core_data_oe && !sleep;
        pad_addr_oe = core_addr_oe && !sleep;
        pad_rd_n    = core_rd_n  || sleep;
        pad_uwr_n   = core_uwr_n || sleep;
        pad_lwr_n   = core_lwr_n || sleep;
        pad_cs_n    = core_cs_n | {CS_N{sleep}};
        pad_clkout  = core_clkout && !sleep;
        core_wait   = ext_wait && !sleep;
        gpio_o      = sleep ? gpio_hold : core_gpio;
    end
endmodule

// File: rtl/lpw_ctrl.sv
// Watch-state controller top: sequences run, watch and stabilization,
// gates the core clocks and issues the acknowledge enable.
// Assumes: synchronous active-low reset; requests are level signals held
// by the interrupt controller until serviced.
module lpw_ctrl
    import lpw_pkg::*;
#(
    parameter int STAB_CYCLES = 5000,
    parameter int IRQ_N       = 8,
    parameter int PRIO_W      = 3,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 24,
    parameter int CS_N        = 3,
    parameter int IO_W        = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pm_wr,
    input  logic [1:0]              pm_code,
    input  logic                    nmi_req,
    input  logic [IRQ_N-1:0]        irq_req,
    input  logic [IRQ_N-1:0]        irq_mask,
    input  logic [IRQ_N*PRIO_W-1:0] irq_prio,
    input  logic                    isr_active,
    input  logic [PRIO_W-1:0]       isr_prio,
    input  logic [DATA_W-1:0]       core_data_o,
    input  logic                    core_data_oe,
    input  logic [ADDR_W-1:0]       core_addr,
    input  logic                    core_addr_oe,
    input  logic                    core_rd_n,
    input  logic                    core_uwr_n,
    input  logic                    core_lwr_n,
    input  logic [CS_N-1:0]         core_cs_n,
    input  logic                    core_clkout,
    input  logic [IO_W-1:0]         core_gpio,
    input  logic                    ext_wait,
    output logic                    cpu_clk_en,
    output logic                    sys_clk_en,
    output logic                    in_watch,
    output logic                    ack_en,
    output logic [DATA_W-1:0]       pad_data_o,
    output logic                    pad_data_oe,
    output logic [ADDR_W-1:0]       pad_addr_o,
    output logic                    pad_addr_oe,
    output logic                    pad_rd_n,
    output logic                    pad_uwr_n,
    output logic                    pad_lwr_n,
    output logic [CS_N-1:0]         pad_cs_n,
    output logic                    pad_clkout,
    output logic                    core_wait,
    output logic [IO_W-1:0]         gpio_o
);
    lpw_state_e state;
    logic       ack_pend;
    logic       wake, grant, stab_done, sleep;

    lpw_wake_eval #(.IRQ_N(IRQ_N), .PRIO_W(PRIO_W)) u_wake (
        .nmi_req(nmi_req), .irq_req(irq_req), .irq_mask(irq_mask),
        .irq_prio(irq_prio), .isr_active(isr_active), .isr_prio(isr_prio),
        .wake(wake), .grant(grant)
    );

    lpw_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_STAB), .done(stab_done)
    );

    // Sequence run -> watch -> stabilization -> run; latch ack decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            ack_pend <= 1'b0;
            ack_en   <= 1'b0;
        end else begin
            ack_en <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (pm_wr && (pm_code == PM_CODE_WATCH))
                        state <= ST_WATCH;
                end
                ST_WATCH: begin
                    if (wake) begin
                        state    <= ST_STAB;
                        ack_pend <= grant;
                    end
                end
                ST_STAB: begin
                    if (stab_done) begin
                        state  <= ST_RUN;
                        ack_en <= ack_pend;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign sleep      = (state != ST_RUN);
    assign cpu_clk_en = !sleep;
    assign sys_clk_en = !sleep;
    assign in_watch   = (state == ST_WATCH);

    lpw_pad_idle #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_N(CS_N), .IO_W(IO_W)) u_pads (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .core_data_o(core_data_o), .core_data_oe(core_data_oe),
        .core_addr(core_addr), .core_addr_oe(core_addr_oe),
        .core_rd_n(core_rd_n), .core_uwr_n(core_uwr_n), .core_lwr_n(core_lwr_n),
        .core_cs_n(core_cs_n), .core_clkout(core_clkout),
        .core_gpio(core_gpio), .ext_wait(ext_wait),
        .pad_data_o(pad_data_o), .pad_data_oe(pad_data_oe),
        .pad_addr_o(pad_addr_o), .pad_addr_oe(pad_addr_oe),
        .pad_rd_n(pad_rd_n), .pad_uwr_n(pad_uwr_n), .pad_lwr_n(pad_lwr_n),
        .pad_cs_n(pad_cs_n), .pad_clkout(pad_clkout),
        .core_wait(core_wait), .gpio_o(gpio_o)
    );
endmodule

// File: rtl/lpw_ctrl_chk.sv
// Protocol checker for lpw_ctrl, attached by bind below.
// Assumes: rst_n low at the first edge.
module lpw_ctrl_chk #(
    parameter int IRQ_N = 8,
    parameter int CS_N  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pm_wr,
    input logic [1:0]       pm_code,
    input logic             nmi_req,
    input logic [IRQ_N-1:0] irq_req,
    input logic [IRQ_N-1:0] irq_mask,
    input logic             cpu_clk_en,
    input logic             sys_clk_en,
    input logic             in_watch,
    input logic             ack_en,
    input logic             pad_data_oe,
    input logic             pad_addr_oe,
    input logic             pad_rd_n,
    input logic             pad_uwr_n,
    input logic             pad_lwr_n,
    input logic [CS_N-1:0]  pad_cs_n,
    input logic             pad_clkout,
    input logic             core_wait
);
    a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && pm_wr && pm_code == 2'b10) |=> (in_watch && !cpu_clk_en && !sys_clk_en));

    a_r2_gated_in_watch: assert property (@(posedge clk) disable iff (!rst_n)
        in_watch |-> (!cpu_clk_en && !sys_clk_en));

    a_r3_masked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (in_watch && !nmi_req && ((irq_req & ~irq_mask) == '0)) |=> in_watch);

    a_r3_wake_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (in_watch && nmi_req) |=> (!in_watch && !cpu_clk_en));

    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |=> !ack_en);

    a_r5_ack_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |-> (cpu_clk_en && !$past(cpu_clk_en)));

    a_r8_pads_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> (!pad_data_oe && !pad_addr_oe && pad_rd_n && pad_uwr_n
                         && pad_lwr_n && (&pad_cs_n) && !pad_clkout));

    a_r9_wait_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> !core_wait);
endmodule

bind lpw_ctrl lpw_ctrl_chk #(.IRQ_N(IRQ_N), .CS_N(CS_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_code(pm_code),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_mask(irq_mask),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .in_watch(in_watch),
    .ack_en(ack_en), .pad_data_oe(pad_data_oe), .pad_addr_oe(pad_addr_oe),
    .pad_rd_n(pad_rd_n), .pad_uwr_n(pad_uwr_n), .pad_lwr_n(pad_lwr_n),
    .pad_cs_n(pad_cs_n), .pad_clkout(pad_clkout), .core_wait(core_wait)
);

// File: tb/sim_lpw_ctrl.sv
// Bench for lpw_ctrl: directed corner cases plus seeded random wake trials.
module sim_lpw_ctrl;
    localparam int L  = 12;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int DW = 16;
    localparam int AW = 24;
    localparam int CW = 3;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pm_wr = 1'b0;
    logic [1:0] pm_code = 2'b00;
    logic nmi_req = 1'b0;
    logic [N-1:0] irq_req = '0, irq_mask = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic isr_active = 1'b0;
    logic [PW-1:0] isr_prio = '0;
    logic [DW-1:0] core_data_o = '0;
    logic core_data_oe = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic core_addr_oe = 1'b0;
    logic core_rd_n = 1'b1, core_uwr_n = 1'b1, core_lwr_n = 1'b1;
    logic [CW-1:0] core_cs_n = '1;
    logic core_clkout = 1'b0;
    logic [IW-1:0] core_gpio = '0;
    logic ext_wait = 1'b0;
    logic cpu_clk_en, sys_clk_en, in_watch, ack_en;
    logic [DW-1:0] pad_data_o;
    logic pad_data_oe, pad_addr_oe, pad_rd_n, pad_uwr_n, pad_lwr_n, pad_clkout, core_wait;
    logic [AW-1:0] pad_addr_o;
    logic [CW-1:0] pad_cs_n;
    logic [IW-1:0] gpio_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    lpw_ctrl #(.STAB_CYCLES(L), .IRQ_N(N), .PRIO_W(PW), .DATA_W(DW),
               .ADDR_W(AW), .CS_N(CW), .IO_W(IW)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit f_wake(bit nmi, logic [N-1:0] rq, logic [N-1:0] mk);
        return nmi || ((rq & ~mk) != '0);
    endfunction

    function automatic bit f_ack(bit nmi, logic [N-1:0] rq, logic [N-1:0] mk,
                                 logic [N*PW-1:0] pr, bit act, logic [PW-1:0] ip);
        int top = -1;
        for (int i = 0; i < N; i++)
            if (rq[i] && !mk[i] && int'(pr[i*PW +: PW]) > top) top = int'(pr[i*PW +: PW]);
        if (nmi) return 1'b1;
        if (top < 0) return 1'b0;
        return !act || (top > int'(ip));
    endfunction

    task automatic enter_watch();
        @(negedge clk); pm_wr = 1'b1; pm_code = 2'b10;
        @(negedge clk); pm_wr = 1'b0; pm_code = 2'b00;
        chk("R1 in_watch", 64'(in_watch), 64'd1);
        chk("R1 cpu_clk_en", 64'({cpu_clk_en, sys_clk_en}), 64'd0);
    endtask

    // Apply a wake pattern for one edge, then check the timing and ack (R4/R5/R6).
    task automatic wake_and_check(bit nmi, logic [N-1:0] rq, logic [N-1:0] mk,
                                  logic [N*PW-1:0] pr, bit act, logic [PW-1:0] ip,
                                  bit mid_write);
        bit exp_ack;
        exp_ack = f_ack(nmi, rq, mk, pr, act, ip);
        nmi_req = nmi; irq_req = rq; irq_mask = mk; irq_prio = pr;
        isr_active = act; isr_prio = ip;
        @(negedge clk);
        nmi_req = 1'b0; irq_req = '0;
        chk("R3 left watch", 64'(in_watch), 64'd0);
        for (int k = 0; k < L - 1; k++) begin
            if (mid_write && k == 2) begin pm_wr = 1'b1; pm_code = 2'b10; end
            if (mid_write && k == 3) begin pm_wr = 1'b0; pm_code = 2'b00; end
            @(negedge clk);
        end
        chk("R2 R4 still stopped", 64'(cpu_clk_en), 64'd0);
        @(negedge clk);
        chk("R4 restart", 64'(cpu_clk_en), 64'd1);
        chk(exp_ack ? "R5 ack" : "R6 no ack", 64'(ack_en), 64'(exp_ack));
        @(negedge clk);
        chk("R5 single pulse", 64'(ack_en), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset state", 64'({cpu_clk_en, sys_clk_en, in_watch, ack_en}), 64'b1100);

        // R10: pass-through while running
        for (int t = 0; t < 4; t++) begin
            core_data_o = DW'($urandom); core_addr = AW'($urandom);
            core_data_oe = 1'($urandom); core_addr_oe = 1'($urandom);
            core_rd_n = 1'($urandom); core_cs_n = CW'($urandom);
            core_clkout = 1'($urandom); core_gpio = IW'($urandom); ext_wait = 1'($urandom);
            #1;
            chk("R10 passthrough", {pad_data_o, pad_addr_o, pad_data_oe, pad_addr_oe, pad_rd_n,
                pad_cs_n, pad_clkout, gpio_o, core_wait},
                {core_data_o, core_addr, core_data_oe, core_addr_oe, core_rd_n,
                core_cs_n, core_clkout, core_gpio, ext_wait});
            @(negedge clk);
        end

        // R1: other codes do not enter
        @(negedge clk); pm_wr = 1'b1; pm_code = 2'b01;
        @(negedge clk); pm_code = 2'b11;
        @(negedge clk); pm_wr = 1'b0; pm_code = 2'b00;
        chk("R1 wrong code ignored", 64'(cpu_clk_en), 64'd1);

        // R8/R9: pads idle, wait masked, gpio held
        core_data_oe = 1'b1; core_addr_oe = 1'b1; core_rd_n = 1'b0; core_uwr_n = 1'b0;
        core_lwr_n = 1'b0; core_cs_n = '0; core_clkout = 1'b1; core_gpio = 8'h5A;
        @(negedge clk);
        enter_watch();
        core_gpio = 8'hC3; ext_wait = 1'b1;
        #1;
        chk("R8 pads idle", 64'({pad_data_oe, pad_addr_oe, pad_rd_n, pad_uwr_n, pad_lwr_n,
            pad_cs_n, pad_clkout}), 64'({2'b00, 3'b111, {CW{1'b1}}, 1'b0}));
        chk("R9 wait masked", 64'(core_wait), 64'd0);
        chk("R9 gpio held", 64'(gpio_o), 64'h5A);

        // R3: masked request does not wake
        irq_req = 8'h0F; irq_mask = 8'h0F;
        repeat (3) @(negedge clk);
        chk("R3 masked stays", 64'(in_watch), 64'd1);
        irq_req = '0;

        // R6: equal priority in handler -> no ack; R11: write mid-count ignored
        wake_and_check(1'b0, 8'h04, 8'h00, 24'(3'd5) << (2*PW), 1'b1, 3'd5, 1'b1);
        // R5: NMI while handler at top level
        enter_watch();
        wake_and_check(1'b1, 8'h00, 8'h00, '0, 1'b1, 3'd7, 1'b0);

        // R7: reset during stabilization and during watch
        enter_watch();
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R7 reset releases", 64'({cpu_clk_en, in_watch}), 64'b10);
        begin
            int seen = 0;
            for (int k = 0; k < L + 3; k++) begin @(negedge clk); seen += int'(ack_en); end
            chk("R7 no ack after reset", 64'(seen), 64'd0);
        end
        enter_watch();
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R7 reset from watch", 64'(cpu_clk_en), 64'd1);
        // R7: count restarts from zero on next entry
        enter_watch();
        wake_and_check(1'b0, 8'h80, 8'h00, '1, 1'b0, 3'd0, 1'b0);

        // Random trials
        for (int t = 0; t < 40; t++) begin
            logic [N-1:0] rq, mk;
            logic [N*PW-1:0] pr;
            bit nm, ac;
            logic [PW-1:0] ip;
            rq = N'($urandom); mk = N'($urandom); pr = (N*PW)'($urandom);
            nm = ($urandom % 6) == 0; ac = 1'($urandom); ip = PW'($urandom);
            enter_watch();
            if (!f_wake(nm, rq, mk)) begin
                irq_req = rq; irq_mask = mk;
                repeat (2) @(negedge clk);
                chk("R3 random masked stays", 64'(in_watch), 64'd1);
                irq_req = '0;
                nm = 1'b1;
            end
            wake_and_check(nm, rq, mk, pr, ac, ip, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule